// File: doc/BRIEF.md
# Flash Access Protection Gate

This block stands between the requesters of a serial flash and the command engine that drives the flash. Every request carries an operation type, a byte offset and a byte length. The gate answers one cycle later with a response code: grant, deny or invalid. The command engine goes ahead only on a grant.

The gate holds three pieces of protection state:
- A sticky write-protect latch. It can be set but not cleared, except by reset.
- An all-access lock that shuts out command-mode traffic.
- Shadow copies of the flash's two status bytes. They are captured when the lock engages, and readers are served from them while the lock holds.

The protected address window arrives already decoded as a start and a length. A write-protect pin, whose polarity is a parameter, forces the latch on whenever it is asserted during a write, erase or status-register write.

Memory-mapped reads stay open while locked; only command-mode transactions are refused.

Top module: `flash_guard`

## Requirements
- R1: While reset is held, and on the first idle cycle after it: rsp_valid is 0, locked is 0, wp_latched is 0, and stat_out0/stat_out1 equal stat_in0/stat_in1.
- R2: A request sampled with req_valid=1 produces rsp_valid=1 with its rsp_code (0 grant, 1 deny, 2 invalid; code 3 never appears) on the next cycle. A cycle without req_valid gives rsp_valid=0 and changes no state. Operation codes on req_op are: 0 program, 1 erase, 2 status write, 3 lock, 4 latch set, 5 latch clear, 6 mapped read, 7 command read.
- R3: A program, erase, mapped read or command read whose offset+length exceeds FLASH_BYTES is invalid. An end of exactly FLASH_BYTES is allowed.
- R4: A program or erase is denied when max(win_start, offset) < min(win_start+win_len, offset+length). The window end is exclusive, and a zero win_len protects nothing.
- R5: While locked, program, erase and command read are denied. This deny takes precedence over the invalid check.
- R6: Latch set (op 4) sets wp_latched and is granted. Latch clear (op 5) is denied and leaves wp_latched unchanged. Only reset clears the latch.
- R7: A program, erase or status-write request made while the pin is asserted sets wp_latched, whatever its result. The pin alone, without a request, has no effect. With WP_ACTIVE_HIGH=0 the pin is asserted when low.
- R8: Lock (op 3) from the unlocked state captures stat_in0/1 into the shadow, sets locked, and is granted. While locked, stat_out shows the shadow. A lock request while already locked is granted without recapture. When unlocked, stat_out follows stat_in.
- R9: Status write while unlocked is granted. While locked, it is denied if wp_latched or the pin is asserted; otherwise it clears locked and is granted.
- R10: An erase is invalid unless its offset and length are both multiples of SECTOR_BYTES and its length is non-zero.
- R11: A mapped read is granted while locked when in range.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Request strobe |
| req_op | input | 3 | Operation code |
| req_offset | input | ADDR_W | Byte offset |
| req_length | input | ADDR_W+1 | Byte count |
| wp_pin | input | 1 | Write-protect pin, polarity set by WP_ACTIVE_HIGH |
| win_start | input | ADDR_W | Protected window start |
| win_len | input | ADDR_W+1 | Protected window length |
| stat_in0 | input | 8 | Live status byte 0 from the flash |
| stat_in1 | input | 8 | Live status byte 1 from the flash |
| rsp_valid | output | 1 | Response strobe |
| rsp_code | output | 2 | 0 grant, 1 deny, 2 invalid |
| locked | output | 1 | All-access lock state |
| wp_latched | output | 1 | Sticky write-protect latch |
| stat_out0 | output | 8 | Status byte 0 seen by readers |
| stat_out1 | output | 8 | Status byte 1 seen by readers |

## Verification
The hardest case to reach is a locked status write that finds the latch already set while the pin is no longer asserted.

To get there, the stimulus first locks the gate and then issues a status write with the pin asserted. That write sets the latch and is itself denied. The pin is then released and a second status write is issued; it must still be denied.

The stimulus also relocks after a permitted unlock, with fresh live status values. This shows that the shadow is recaptured on each unlocked-to-locked transition and never on a relock.

// File: rtl/fg_pkg.sv
package fg_pkg;

    typedef enum logic [2:0] {
        OP_PROG  = 3'd0,
        OP_ERASE = 3'd1,
        OP_SRWR  = 3'd2,
        OP_LOCK  = 3'd3,
        OP_WPSET = 3'd4,
        OP_WPCLR = 3'd5,
        OP_MAPRD = 3'd6,
        OP_CMDRD = 3'd7
    } op_e;

    localparam logic [1:0] RC_GRANT = 2'd0;
    localparam logic [1:0] RC_DENY  = 2'd1;
    localparam logic [1:0] RC_INVAL = 2'd2;

    typedef struct packed {
        logic       lock;
        logic       wpl;
        logic [7:0] sh0;
        logic [7:0] sh1;
        logic       rv;
        logic [1:0] rc;
    } gate_st_t;

endpackage

// File: rtl/fg_pin_norm.sv
module fg_pin_norm #(
    parameter bit ACTIVE_HIGH = 1'b0
) (
    input  logic pin_raw,
    output logic pin_act
);
    generate
        if (ACTIVE_HIGH) begin : g_hi
            assign pin_act = pin_raw;
        end else begin : g_lo
            assign pin_act = ~pin_raw;
        end
    endgenerate
endmodule

// File: rtl/fg_range_chk.sv
module fg_range_chk #(
    parameter int unsigned FLASH_BYTES  = 65536,
    parameter int unsigned SECTOR_BYTES = 4096,
    localparam int unsigned AW     = $clog2(FLASH_BYTES),
    localparam int unsigned LW     = AW + 1,
    localparam int unsigned SW     = AW + 2,
    localparam int unsigned SEC_LG = $clog2(SECTOR_BYTES)
) (
    input  logic [AW-1:0] off,
    input  logic [LW-1:0] len,
    input  logic [AW-1:0] w_start,
    input  logic [LW-1:0] w_len,
    output logic          oob,
    output logic          overlap,
    output logic          misalign
);
    logic [SW-1:0] r_lo, r_hi, w_lo, w_hi, lo_max, hi_min;

    always_comb begin
        r_lo   = {2'b00, off};
        r_hi   = r_lo + {1'b0, len};
        w_lo   = {2'b00, w_start};
        w_hi   = w_lo + {1'b0, w_len};
        lo_max = (w_lo > r_lo) ? w_lo : r_lo;
        hi_min = (w_hi < r_hi) ? w_hi : r_hi;
        oob      = r_hi > SW'(FLASH_BYTES);
        overlap  = lo_max < hi_min;
        misalign = (off[SEC_LG-1:0] != '0) || (len[SEC_LG-1:0] != '0) || (len == '0);
    end
endmodule

// File: rtl/flash_guard.sv
module flash_guard
    import fg_pkg::*;
#(
    parameter int unsigned FLASH_BYTES    = 65536,
    parameter int unsigned SECTOR_BYTES   = 4096,
    parameter bit          WP_ACTIVE_HIGH = 1'b0,
    localparam int unsigned ADDR_W = $clog2(FLASH_BYTES)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic [2:0]        req_op,
    input  logic [ADDR_W-1:0] req_offset,
    input  logic [ADDR_W:0]   req_length,
    input  logic              wp_pin,
    input  logic [ADDR_W-1:0] win_start,
    input  logic [ADDR_W:0]   win_len,
    input  logic [7:0]        stat_in0,
    input  logic [7:0]        stat_in1,
    output logic              rsp_valid,
    output logic [1:0]        rsp_code,
    output logic              locked,
    output logic              wp_latched,
    output logic [7:0]        stat_out0,
    output logic [7:0]        stat_out1
);
    gate_st_t st_d, st_q;
    logic     pin_act, oob, overlap, misalign;
    op_e      op;

    assign op = op_e'(req_op);

    fg_pin_norm #(.ACTIVE_HIGH(WP_ACTIVE_HIGH)) u_pin (
        .pin_raw (wp_pin),
        .pin_act (pin_act)
    );

    fg_range_chk #(.FLASH_BYTES(FLASH_BYTES), .SECTOR_BYTES(SECTOR_BYTES)) u_rng (
        .off      (req_offset),
        .len      (req_length),
        .w_start  (win_start),
        .w_len    (win_len),
        .oob      (oob),
        .overlap  (overlap),
        .misalign (misalign)
    );

    always_comb begin
        st_d    = st_q;
        st_d.rv = 1'b0;
        st_d.rc = RC_GRANT;
        if (req_valid) begin
            st_d.rv = 1'b1;
            case (op)
                OP_PROG, OP_ERASE: begin
                    if (pin_act) st_d.wpl = 1'b1;
                    if (st_q.lock)                      st_d.rc = RC_DENY;
                    else if (oob)                       st_d.rc = RC_INVAL;
                    else if (op == OP_ERASE && misalign) st_d.rc = RC_INVAL;
                    else if (overlap)                   st_d.rc = RC_DENY;
                    else                                st_d.rc = RC_GRANT;
                end
                OP_SRWR: begin
                    if (pin_act) st_d.wpl = 1'b1;
                    if (st_q.lock) begin
                        if (st_q.wpl || pin_act) begin
                            st_d.rc = RC_DENY;
                        end else begin
                            st_d.lock = 1'b0;
                            st_d.rc   = RC_GRANT;
                        end
                    end
                end
                OP_LOCK: begin
                    if (!st_q.lock) begin
                        st_d.sh0 = stat_in0;
                        st_d.sh1 = stat_in1;
                    end
                    st_d.lock = 1'b1;
                end
                OP_WPSET: st_d.wpl = 1'b1;
                OP_WPCLR: st_d.rc  = RC_DENY;
                OP_MAPRD: st_d.rc  = oob ? RC_INVAL : RC_GRANT;
                OP_CMDRD: begin
                    if (st_q.lock) st_d.rc = RC_DENY;
                    else if (oob)  st_d.rc = RC_INVAL;
                end
                default: st_d.rc = RC_INVAL;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign rsp_valid  = st_q.rv;
    assign rsp_code   = st_q.rc;
    assign locked     = st_q.lock;
    assign wp_latched = st_q.wpl;
    assign stat_out0  = st_q.lock ? st_q.sh0 : stat_in0;
    assign stat_out1  = st_q.lock ? st_q.sh1 : stat_in1;

    // R2
    no_spurious_rsp_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> !rsp_valid);

    // R2
    legal_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> rsp_code != 2'b11);

    // R3
    oob_invalid_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && op == OP_PROG && !locked && oob) |=> rsp_code == RC_INVAL);

    // R5
    lock_blocks_prog_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && locked && (op == OP_PROG || op == OP_ERASE)) |=> rsp_code == RC_DENY);

    // R6
    latch_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wp_latched |=> wp_latched);

    // R8
    shadow_capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && op == OP_LOCK && !locked) |=>
            (locked && stat_out0 == $past(stat_in0) && stat_out1 == $past(stat_in1)));

    // R8
    shadow_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        locked |=> $stable(st_q.sh0) && $stable(st_q.sh1));

endmodule

// File: tb/tb_flash_guard.sv
module tb_flash_guard;
    localparam int CLK_PERIOD = 10;
    localparam int FBYTES     = 65536;
    localparam int SBYTES     = 4096;
    localparam bit WPH        = 1'b0;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic [2:0]  req_op = '0;
    logic [15:0] req_offset = '0;
    logic [16:0] req_length = '0;
    logic        wp_pin = ~WPH;
    logic [15:0] win_start = '0;
    logic [16:0] win_len = '0;
    logic [7:0]  stat_in0 = '0, stat_in1 = '0;
    logic        rsp_valid, locked, wp_latched;
    logic [1:0]  rsp_code;
    logic [7:0]  stat_out0, stat_out1;

    int n_chk = 0, n_fail = 0;
    bit done = 0;
    int m_lock = 0, m_wpl = 0, m_sh0 = 0, m_sh1 = 0;
    int wst = 4096, wln = 4096;
    int sin0 = 0, sin1 = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    flash_guard #(.FLASH_BYTES(FBYTES), .SECTOR_BYTES(SBYTES), .WP_ACTIVE_HIGH(WPH)) dut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_op(req_op),
        .req_offset(req_offset), .req_length(req_length), .wp_pin(wp_pin),
        .win_start(win_start), .win_len(win_len), .stat_in0(stat_in0), .stat_in1(stat_in1),
        .rsp_valid(rsp_valid), .rsp_code(rsp_code), .locked(locked), .wp_latched(wp_latched),
        .stat_out0(stat_out0), .stat_out1(stat_out1));

    task automatic chk(input string tag, input string what, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
        end
    endtask

    task automatic compare(input string tag, input int e_rv, input int e_rc);
        chk(tag, "rsp_valid", int'(rsp_valid), e_rv);
        if (e_rv != 0) chk(tag, "rsp_code", int'(rsp_code), e_rc);
        chk(tag, "locked", int'(locked), m_lock);
        chk(tag, "wp_latched", int'(wp_latched), m_wpl);
        chk(tag, "stat_out0", int'(stat_out0), (m_lock != 0) ? m_sh0 : sin0);
        chk(tag, "stat_out1", int'(stat_out1), (m_lock != 0) ? m_sh1 : sin1);
    endtask

    // Drive at a falling edge, predict, then compare at the next falling edge.
    task automatic step(input string tag, input bit v, input int op, input int off,
                        input int len, input bit pin_on);
        int e_rc, endp, lo, hi;
        bit oob, ov, mis;
        req_valid  = v;
        req_op     = op[2:0];
        req_offset = off[15:0];
        req_length = len[16:0];
        wp_pin     = WPH ? pin_on : ~pin_on;
        win_start  = wst[15:0];
        win_len    = wln[16:0];
        stat_in0   = sin0[7:0];
        stat_in1   = sin1[7:0];
        endp = off + len;
        oob  = endp > FBYTES;
        lo   = (wst > off) ? wst : off;
        hi   = ((wst + wln) < endp) ? (wst + wln) : endp;
        ov   = lo < hi;
        mis  = (off % SBYTES != 0) || (len % SBYTES != 0) || (len == 0);
        e_rc = 0;
        if (v) begin
            case (op)
                0, 1: begin
                    if (pin_on) m_wpl = 1;
                    if (m_lock != 0) e_rc = 1;
                    else if (oob) e_rc = 2;
                    else if (op == 1 && mis) e_rc = 2;
                    else if (ov) e_rc = 1;
                end
                2: begin
                    if (m_lock != 0) begin
                        if (m_wpl != 0 || pin_on) e_rc = 1;
                        else m_lock = 0;
                    end
                    if (pin_on) m_wpl = 1;
                end
                3: begin
                    if (m_lock == 0) begin m_sh0 = sin0; m_sh1 = sin1; end
                    m_lock = 1;
                end
                4: m_wpl = 1;
                5: e_rc = 1;
                6: e_rc = oob ? 2 : 0;
                default: e_rc = (m_lock != 0) ? 1 : (oob ? 2 : 0);
            endcase
        end
        @(posedge clk);
        @(negedge clk);
        compare(tag, v ? 1 : 0, e_rc);
    endtask

    task automatic do_reset(input string tag);
        @(negedge clk);
        rst_n = 1'b0;
        req_valid = 1'b0;
        m_lock = 0; m_wpl = 0; m_sh0 = 0; m_sh1 = 0;
        @(posedge clk);
        @(negedge clk);
        compare(tag, 0, 0);
        rst_n = 1'b1;
    endtask

    initial begin
        // Reset state: R1
        do_reset("R1");
        step("R1", 0, 0, 0, 0, 0);
        step("R2", 0, 3, 0, 0, 0);               // idle with a lock op on the bus
        step("R2", 1, 0, 0, 16, 0);
        // Window boundaries: R4
        step("R4", 1, 0, 16'h0FF0, 16'h10, 0);
        step("R4", 1, 0, 16'h0FF0, 16'h11, 0);
        step("R4", 1, 0, 16'h2000, 4, 0);
        step("R4", 1, 0, 16'h1FFF, 1, 0);
        step("R4", 1, 1, 16'h1000, 16'h1000, 0);
        wln = 0;
        step("R4", 1, 0, 16'h1000, 16'h100, 0);
        wln = 4096;
        // Size limit: R3
        step("R3", 1, 0, 16'hFFF0, 16'h10, 0);
        step("R3", 1, 0, 16'hFFF0, 16'h11, 0);
        step("R3", 1, 6, 16'hFF00, 16'h200, 0);
        step("R3", 1, 7, 16'h4000, 16'h20, 0);
        step("R3", 1, 7, 16'h8000, 17'h10000, 0);
        // Erase alignment: R10
        step("R10", 1, 1, 16'h3000, 16'h1000, 0);
        step("R10", 1, 1, 16'h3001, 16'h1000, 0);
        step("R10", 1, 1, 16'h3000, 16'h0800, 0);
        step("R10", 1, 1, 16'h3000, 0, 0);
        // Status write unlocked: R9
        step("R9", 1, 2, 0, 0, 0);
        // Lock with capture: R8
        sin0 = 8'hA5; sin1 = 8'h3C;
        step("R8", 1, 3, 0, 0, 0);
        sin0 = 8'h11; sin1 = 8'h22;
        step("R8", 0, 0, 0, 0, 0);
        step("R8", 1, 3, 0, 0, 0);
        // Locked refusals: R5
        step("R5", 1, 0, 0, 16, 0);
        step("R5", 1, 1, 16'h3000, 16'h1000, 0);
        step("R5", 1, 7, 0, 16, 0);
        step("R5", 1, 0, 16'hFFF0, 16'h20, 0);
        // Mapped read while locked: R11
        step("R11", 1, 6, 16'h1000, 16'h40, 0);
        step("R11", 1, 6, 16'hFFFF, 2, 0);
        // Latch clear refused: R6
        step("R6", 1, 5, 0, 0, 0);
        // Unlock via status write: R9
        step("R9", 1, 2, 0, 0, 0);
        step("R8", 0, 0, 0, 0, 0);
        step("R8", 1, 3, 0, 0, 0);
        sin0 = 8'h5A;
        step("R8", 0, 0, 0, 0, 0);
        // Pin assertion while locked: R7 / R9
        step("R7", 0, 0, 0, 0, 1);
        step("R9", 1, 2, 0, 0, 1);
        step("R9", 1, 2, 0, 0, 0);
        step("R6", 1, 5, 0, 0, 0);
        // Reset clears the latch: R6
        do_reset("R6");
        step("R6", 1, 4, 0, 0, 0);
        step("R6", 1, 5, 0, 0, 0);
        do_reset("R1");
        // Pin during an unlocked program: R7
        step("R7", 1, 0, 16'h4000, 8, 1);
        step("R7", 0, 0, 0, 0, 0);
        do_reset("R1");
        step("R7", 1, 1, 16'h1000, 16'h1000, 1);
        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
            $finish;
        end
    end
endmodule